// File: doc/BRIEF.md
# Floating-Point Operand Unpack Stage

This block sits at the front of a floating-point datapath. It accepts one 128-bit register operand with a type code. The type code says whether the operand is a 32-bit or 64-bit two's-complement integer, or an IEEE 754 single, double or quad value. The block rewrites the operand into one internal form. That form has a sign, a five-way class code, an unbiased signed exponent and a 113-bit mantissa. For every finite nonzero value, the leading one of the mantissa sits at bit 112. Integers and denormals are normalized to that position. A signalling NaN is quieted, and the invalid-operation flag is raised at this stage.

All operands are taken from the upper end of the input word. Bit 127 always carries the sign. The exponent field follows directly below it, then the fraction. The fraction of each float width is left-aligned into mantissa bits 111 down, so a normal value of any width puts its implied one at bit 112. Integers use the top 32 or 64 bits.

Control is a two-state machine: ST_IDLE and ST_PRESENT. The transitions are:
- LOAD: ST_IDLE to ST_PRESENT, taken on `in_valid`.
- RELOAD: ST_PRESENT to ST_PRESENT, taken on `in_valid`.
- DRAIN: ST_PRESENT to ST_IDLE, taken when `in_valid` is low.
- REST: ST_IDLE to ST_IDLE, taken when `in_valid` is low.

`out_valid` is high while the machine is in ST_PRESENT. The result registers load only when `in_valid` is high.

Top module: `fpu_unpack`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, and low otherwise. A synchronous active-high `rst` clears `out_valid`, `out_invalid` and `out_type_err`.
- R2: For every supported type, `out_sign` equals bit 127 of `in_word`.
- R3: Type codes are 0 = 32-bit integer (bits 127:96), 1 = 64-bit integer (bits 127:64), 2 = single, 3 = double and 4 = quad. The float layouts are:
  - single: exponent 126:119 and fraction 118:96, bias 127;
  - double: exponent 126:116 and fraction 115:64, bias 1023;
  - quad: exponent 126:112 and fraction 111:0, bias 16383.

  Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN.
- R4: An integer equal to zero gives class zero, with exponent 0 and mantissa 0. A nonzero integer is converted to its magnitude (negated when negative). The output exponent is then the bit index of the magnitude's leading one, and the mantissa is the magnitude shifted so that the leading one is at bit 112.
- R5: A float with exponent field 0 and fraction 0 gives class zero, with exponent 0 and mantissa 0.
- R6: A float with exponent field 0 and a nonzero fraction gives class number. It gets no implied one, and it is normalized so that its leading one lands at bit 112, with exponent (1 - bias) minus the shift distance.
- R7: A float with an exponent field that is neither 0 nor all ones gives class number. Its exponent is the field minus the bias, and its mantissa has a one at bit 112 with the fraction left-aligned below it.
- R8: A float with an all-ones exponent field and fraction 0 gives class infinity, with exponent 0 and mantissa 0.
- R9: A float with an all-ones exponent field, a nonzero fraction and the top fraction bit set gives class quiet NaN. The left-aligned fraction is passed through without normalization, the exponent is 0, and `out_invalid` stays low.
- R10: A float with an all-ones exponent field, a nonzero fraction and the top fraction bit clear gives class signalling NaN. Mantissa bit 111 is set over the passed-through fraction, and `out_invalid` is high with `out_valid`.
- R11: `out_sticky` is always 0. `out_invalid` is high only when class signalling NaN is presented.
- R12: A type code of 5, 6 or 7 gives `out_type_err` high with `out_valid`. The class is zero, and the sign, exponent, mantissa and `out_invalid` are all 0.
- R13: While `in_valid` is low, the sign, class, exponent and mantissa outputs hold their last values, and `out_invalid` and `out_type_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_type | input | 3 | Operand type code |
| in_word | input | 128 | Raw operand, upper-aligned |
| out_valid | output | 1 | Result present, one cycle after the strobe |
| out_sign | output | 1 | Sign of the operand |
| out_class | output | 3 | Class code |
| out_exp | output | 18 | Unbiased signed exponent |
| out_mant | output | 113 | Mantissa, leading one at bit 112 |
| out_sticky | output | 1 | Sticky bit, always zero |
| out_invalid | output | 1 | Invalid-operation flag (signalling NaN input) |
| out_type_err | output | 1 | Unsupported type code |

## Verification
The bench targets the smallest denormals of single and quad. These need the longest normalizing shifts (23 and 112 places), so a leading-zero count or exponent adjust that is off by one shows up as a wrong exponent such as -148 or -16493. The most negative 32-bit integer and the value -1 exercise the magnitude step: a design that skipped the negation, or read the sign from the wrong bit, would produce a mantissa full of ones or a sign of 0. The NaN cases separate the two kinds by the top fraction bit. A design that failed to set bit 111 for a signalling NaN, or raised `out_invalid` for a quiet one, is caught there. Idle cycles after a signalling NaN expose a flag that stays high, or data that changes without a strobe.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
    localparam int OP_W   = 128;
    localparam int QFRAC  = 112;
    localparam int MANT_W = QFRAC + 1;
    localparam int LEAD   = QFRAC;
    localparam int EXP_W  = 18;
    localparam int LZ_W   = $clog2(MANT_W + 1);

    localparam logic [2:0] TY_I32  = 3'd0;
    localparam logic [2:0] TY_I64  = 3'd1;
    localparam logic [2:0] TY_SGL  = 3'd2;
    localparam logic [2:0] TY_DBL  = 3'd3;
    localparam logic [2:0] TY_QUAD = 3'd4;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_class_e;

    // Split result before normalization
    typedef struct packed {
        fp_class_e                 cls;
        logic                      sign;
        logic signed [EXP_W-1:0]   exp;
        logic [MANT_W-1:0]         mant;
        logic                      do_norm;
        logic                      inv;
        logic                      err;
    } split_t;

    // Final unpacked result
    typedef struct packed {
        fp_class_e                 cls;
        logic                      sign;
        logic signed [EXP_W-1:0]   exp;
        logic [MANT_W-1:0]         mant;
        logic                      inv;
        logic                      err;
    } res_t;
endpackage

// File: rtl/fpu_int_split.sv
module fpu_int_split
    import fpu_unpack_pkg::*;
#(
    parameter int INT_BITS = 32
) (
    input  logic [INT_BITS-1:0] word,
    output split_t              res
);
    logic [INT_BITS-1:0] mag;

    always_comb begin
        mag = word[INT_BITS-1] ? (~word + 1'b1) : word;
        res = '0;
        res.sign = word[INT_BITS-1];
        res.cls  = CLS_ZERO;
        if (|word) begin
            res.cls     = CLS_NUM;
            res.exp     = EXP_W'(LEAD);
            res.mant    = MANT_W'(mag);
            res.do_norm = 1'b1;
        end
    end
endmodule

// File: rtl/fpu_float_split.sv
module fpu_float_split
    import fpu_unpack_pkg::*;
#(
    parameter int EXP_BITS  = 8,
    parameter int FRAC_BITS = 23
) (
    input  logic [EXP_BITS+FRAC_BITS:0] word,
    output split_t                      res
);
    localparam int BIAS = (1 << (EXP_BITS - 1)) - 1;

    logic [EXP_BITS-1:0]  efield;
    logic [FRAC_BITS-1:0] frac;
    logic [QFRAC-1:0]     aligned;

    always_comb begin
        efield  = word[EXP_BITS+FRAC_BITS-1 -: EXP_BITS];
        frac    = word[FRAC_BITS-1:0];
        aligned = QFRAC'(frac) << (QFRAC - FRAC_BITS);
        res = '0;
        res.sign = word[EXP_BITS+FRAC_BITS];
        res.cls  = CLS_ZERO;
        if (efield == '0) begin
            if (|frac) begin
                res.cls     = CLS_NUM;
                res.exp     = EXP_W'(1 - BIAS);
                res.mant    = {1'b0, aligned};
                res.do_norm = 1'b1;
            end
        end else if (&efield) begin
            if (!(|frac)) begin
                res.cls = CLS_INF;
            end else if (aligned[QFRAC-1]) begin
                res.cls  = CLS_QNAN;
                res.mant = {1'b0, aligned};
            end else begin
                res.cls  = CLS_SNAN;
                res.mant = {2'b01, aligned[QFRAC-2:0]};
                res.inv  = 1'b1;
            end
        end else begin
            res.cls  = CLS_NUM;
            res.exp  = $signed(EXP_W'(efield)) - $signed(EXP_W'(BIAS));
            res.mant = {1'b1, aligned};
        end
    end
endmodule

// File: rtl/fpu_norm_shift.sv
module fpu_norm_shift
    import fpu_unpack_pkg::*;
(
    input  split_t pre,
    output res_t   res
);
    logic [LZ_W-1:0] lz;
    logic            found;

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!found && pre.mant[i]) begin
                lz    = LZ_W'(MANT_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        res.cls  = pre.cls;
        res.sign = pre.sign;
        res.inv  = pre.inv;
        res.err  = pre.err;
        res.exp  = pre.exp;
        res.mant = pre.mant;
        if (pre.do_norm) begin
            res.mant = pre.mant << lz;
            res.exp  = pre.exp - $signed(EXP_W'(lz));
        end
    end
endmodule

// File: rtl/fpu_unpack.sv
module fpu_unpack
    import fpu_unpack_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [2:0]               in_type,
    input  logic [OP_W-1:0]          in_word,
    output logic                     out_valid,
    output logic                     out_sign,
    output logic [2:0]               out_class,
    output logic signed [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0]        out_mant,
    output logic                     out_sticky,
    output logic                     out_invalid,
    output logic                     out_type_err
);
    typedef enum logic {ST_IDLE, ST_PRESENT} state_e;

    state_e state_q, state_d;
    split_t s_i32, s_i64, s_sgl, s_dbl, s_quad, s_sel;
    res_t   r_norm, r_q;

    fpu_int_split #(.INT_BITS(32)) u_i32 (.word(in_word[OP_W-1 -: 32]), .res(s_i32));
    fpu_int_split #(.INT_BITS(64)) u_i64 (.word(in_word[OP_W-1 -: 64]), .res(s_i64));

    fpu_float_split #(.EXP_BITS(8),  .FRAC_BITS(23))  u_sgl
        (.word(in_word[OP_W-1 -: 32]),  .res(s_sgl));
    fpu_float_split #(.EXP_BITS(11), .FRAC_BITS(52))  u_dbl
        (.word(in_word[OP_W-1 -: 64]),  .res(s_dbl));
    fpu_float_split #(.EXP_BITS(15), .FRAC_BITS(112)) u_quad
        (.word(in_word),                .res(s_quad));

    always_comb begin
        s_sel = '0;
        unique case (in_type)
            TY_I32:  s_sel = s_i32;
            TY_I64:  s_sel = s_i64;
            TY_SGL:  s_sel = s_sgl;
            TY_DBL:  s_sel = s_dbl;
            TY_QUAD: s_sel = s_quad;
            default: begin
                s_sel     = '0;
                s_sel.cls = CLS_ZERO;
                s_sel.err = 1'b1;
            end
        endcase
    end

    fpu_norm_shift u_norm (.pre(s_sel), .res(r_norm));

    // State register and result capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            r_q     <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                r_q <= r_norm;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = in_valid ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = in_valid ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        out_valid    = (state_q == ST_PRESENT);
        out_sign     = r_q.sign;
        out_class    = r_q.cls;
        out_exp      = r_q.exp;
        out_mant     = r_q.mant;
        out_sticky   = 1'b0;
        out_invalid  = out_valid & r_q.inv;
        out_type_err = out_valid & r_q.err;
    end
endmodule

// File: rtl/fpu_unpack_chk.sv
module fpu_unpack_chk
    import fpu_unpack_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic [2:0]               out_class,
    input logic signed [EXP_W-1:0]  out_exp,
    input logic [MANT_W-1:0]        out_mant,
    input logic                     out_sticky,
    input logic                     out_invalid,
    input logic                     out_type_err
);
    // R1
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R11
    invalid_only_snan_chk: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_valid && out_class == CLS_SNAN));
    // R11
    sticky_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_sticky == 1'b0);
    // R4
    num_normalized_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == CLS_NUM) |-> out_mant[MANT_W-1]);
    // R12
    type_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_type_err |-> (out_valid && out_class == CLS_ZERO && out_mant == '0));
    // R13
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_mant) && $stable(out_exp) && $stable(out_class)));
endmodule

bind fpu_unpack fpu_unpack_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_class(out_class), .out_exp(out_exp), .out_mant(out_mant),
    .out_sticky(out_sticky), .out_invalid(out_invalid),
    .out_type_err(out_type_err)
);

// File: tb/fpu_unpack_tb_top.sv
`timescale 1ns/1ps
module fpu_unpack_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   in_type = 3'd0;
    logic [127:0] in_word = '0;
    logic         out_valid, out_sign, out_sticky, out_invalid, out_type_err;
    logic [2:0]   out_class;
    logic signed [17:0] out_exp;
    logic [112:0] out_mant;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [112:0] ONE = 113'(1) << 112;

    fpu_unpack dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type),
        .in_word(in_word), .out_valid(out_valid), .out_sign(out_sign),
        .out_class(out_class), .out_exp(out_exp), .out_mant(out_mant),
        .out_sticky(out_sticky), .out_invalid(out_invalid),
        .out_type_err(out_type_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [127:0] w, input logic [2:0] t);
        @(negedge clk);
        in_word  = w;
        in_type  = t;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic s, input logic [2:0] c,
                              input int e, input logic [112:0] m, input logic inv);
        chk({tag, " R1 valid"}, 128'(out_valid), 128'(1));
        chk({tag, " R2 sign"}, 128'(out_sign), 128'(s));
        chk({tag, " class"}, 128'(out_class), 128'(c));
        chk({tag, " exp"}, 128'(out_exp), 128'(18'(e)));
        chk({tag, " mant"}, 128'(out_mant), 128'(m));
        chk({tag, " R11 invalid"}, 128'(out_invalid), 128'(inv));
        chk({tag, " R11 sticky"}, 128'(out_sticky), 128'(0));
    endtask

    task automatic t_reset();
        chk("R1 reset valid", 128'(out_valid), 128'(0));
        chk("R1 reset invalid", 128'(out_invalid), 128'(0));
        chk("R1 reset type_err", 128'(out_type_err), 128'(0));
    endtask

    task automatic t_normals();
        apply({32'h3F80_0000, 96'h0}, 3'd2);
        expect_res("R7 R3 single 1.0", 1'b0, 3'd1, 0, ONE, 1'b0);
        apply({32'hC020_0000, 96'h0}, 3'd2);
        expect_res("R7 single -2.5", 1'b1, 3'd1, 1, ONE | (113'(1) << 110), 1'b0);
        apply({16'h3FFF, 112'h0}, 3'd4);
        expect_res("R7 quad 1.0", 1'b0, 3'd1, 0, ONE, 1'b0);
        apply({16'h7FFE, 112'h0}, 3'd4);
        expect_res("R7 quad max exp", 1'b0, 3'd1, 16383, ONE, 1'b0);
    endtask

    task automatic t_zero_denorm();
        apply({32'h8000_0000, 96'h0}, 3'd2);
        expect_res("R5 single -0", 1'b1, 3'd0, 0, '0, 1'b0);
        apply({32'h0000_0001, 96'h0}, 3'd2);
        expect_res("R6 single min denorm", 1'b0, 3'd1, -149, ONE, 1'b0);
        apply({64'h0008_0000_0000_0000, 64'h0}, 3'd3);
        expect_res("R6 double denorm", 1'b0, 3'd1, -1023, ONE, 1'b0);
        apply(128'h1, 3'd4);
        expect_res("R6 quad min denorm", 1'b0, 3'd1, -16494, ONE, 1'b0);
    endtask

    task automatic t_ints();
        apply({32'hFFFF_FFFF, 96'h0}, 3'd0);
        expect_res("R4 int32 -1", 1'b1, 3'd1, 0, ONE, 1'b0);
        apply({32'h8000_0000, 96'h0}, 3'd0);
        expect_res("R4 int32 min", 1'b1, 3'd1, 31, ONE, 1'b0);
        apply({64'd5, 64'h0}, 3'd1);
        expect_res("R4 int64 5", 1'b0, 3'd1, 2, ONE | (113'(1) << 110), 1'b0);
        apply({32'h0, 96'hFFFF}, 3'd0);
        expect_res("R4 int32 zero", 1'b0, 3'd0, 0, '0, 1'b0);
    endtask

    task automatic t_specials();
        apply({32'h7F80_0000, 96'h0}, 3'd2);
        expect_res("R8 single inf", 1'b0, 3'd2, 0, '0, 1'b0);
        apply({64'h7FF8_0000_0000_0001, 64'h0}, 3'd3);
        expect_res("R9 double qnan", 1'b0, 3'd3, 0,
                   (113'(1) << 111) | (113'(1) << 60), 1'b0);
        apply({32'hFF80_0001, 96'h0}, 3'd2);
        expect_res("R10 single snan", 1'b1, 3'd4, 0,
                   (113'(1) << 111) | (113'(1) << 89), 1'b1);
        // R13: idle cycle after the SNaN, with garbage on the inputs
        @(negedge clk);
        in_word = '1;
        in_type = 3'd2;
        chk("R13 idle valid", 128'(out_valid), 128'(0));
        chk("R13 idle invalid", 128'(out_invalid), 128'(0));
        chk("R13 idle mant hold", 128'(out_mant),
            128'((113'(1) << 111) | (113'(1) << 89)));
        chk("R13 idle class hold", 128'(out_class), 128'(4));
    endtask

    task automatic t_bad_type();
        apply({32'hBF80_0000, 96'h0}, 3'd6);
        chk("R12 type_err", 128'(out_type_err), 128'(1));
        expect_res("R12 bad type", 1'b0, 3'd0, 0, '0, 1'b0);
        @(negedge clk);
        chk("R12 type_err clears", 128'(out_type_err), 128'(0));
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_word  = {32'h4000_0000, 96'h0};
        in_type  = 3'd2;
        in_valid = 1'b1;
        @(negedge clk);
        expect_res("R1 b2b first", 1'b0, 3'd1, 1, ONE, 1'b0);
        in_word = {64'hBFF0_0000_0000_0000, 64'h0};
        in_type = 3'd3;
        @(negedge clk);
        in_valid = 1'b0;
        expect_res("R1 b2b second", 1'b1, 3'd1, 0, ONE, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_normals();
        t_zero_denorm();
        t_ints();
        t_specials();
        t_bad_type();
        t_back_to_back();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule